// File: doc/BRIEF.md
# Pseudorandom-Traversal Memory Checksum Engine

This engine produces a 64-bit attestation checksum over a byte-wide memory addressed with 16 bits. A remote checker sends a 16-byte challenge and an iteration count. The challenge seeds a byte-permutation keystream generator. The engine throws away the first 256 keystream bytes. It takes the next eight bytes as the starting checksum lanes, and one further byte as the initial "previous" byte. After that it runs the requested number of read-and-mix iterations.

Each read address joins two bytes: the fresh keystream byte is the upper half, and the checksum lane written in the previous iteration is the lower half. Each lane update folds in the byte read from memory, an older lane and the previous keystream byte. Because of this, the visiting order cannot be predicted without the challenge, and one iteration cannot start before the one before it ends. A free-running cycle meter reports how long the whole computation took. The checker can compare this figure against the expected time.

Top module: `trav_csum_engine`

## Requirements
- R1: After reset, `done`, `busy` and `mem_rd` are 0, `cycles` is 0 and all checksum bytes are 0.
- R2: The keystream permutation starts as the identity. It is mixed by the standard 256-step key schedule, with key byte k taken from `seed[8k+7:8k]` and the 16 key bytes repeated cyclically. Bytes come from the usual increment/add/swap/lookup step. Bytes 0 to 255 are discarded.
- R3: Keystream bytes 256..263 load lanes C0..C7, and lane k is output on `csum[8k+7:8k]`. Byte 264 loads the previous-byte register. With `iters` = 0 the engine finishes with exactly these lanes.
- R4: Iteration n issues exactly one single-cycle `mem_rd` pulse. Its address is {keystream byte 265+n, C[(j-1) mod 8]}. The address stays stable until the next pulse, and a run issues exactly `iters` pulses.
- R5: The lane index j starts at 0. Each iteration sets C[j] to rotate-left-by-1 of (C[j] + ((rdata XOR C[(j-2) mod 8]) + prev)) mod 256. It then makes prev equal to the keystream byte used for the address and advances j modulo 8.
- R6: `mem_rdata` is sampled MEM_LAT clock edges after the edge that raised `mem_rd`, so each iteration costs exactly MEM_LAT+2 cycles.
- R7: A `start` pulse while `busy` is high is ignored: the running job's result and cycle count are unchanged.
- R8: `done` rises at the end of a run and stays high, with `csum` stable, until the next accepted `start`.
- R9: `cycles` clears on an accepted start and increments on every busy cycle. It then freezes when `done` rises. With defaults it equals 522 + iters*(MEM_LAT+2).
- R10: `busy` is high from the cycle after an accepted start until `done` rises, and `done` only rises directly from a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle or done |
| seed | input | KEY_BYTES*8 | Challenge; byte k at bits 8k+7:8k |
| iters | input | ITER_W | Number of read-and-mix iterations |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid MEM_LAT edges after the strobe |
| csum | output | LANES*8 | Checksum lanes, lane k at bits 8k+7:8k |
| done | output | 1 | Run finished; held until next start |
| busy | output | 1 | Run in progress |
| cycles | output | CYC_W | Cycles spent on the current or last run |

## Verification
Some properties are checked by assertions on every cycle:
- the read strobe is a single-cycle pulse and the address holds after it;
- the keystream is only stepped after its key schedule has finished;
- the cycle meter advances by exactly one per busy cycle and freezes once done;
- a start while busy never clears the meter;
- done only rises out of a busy cycle.

The bench scenarios are needed for the rest. They check the actual checksum value against an independent model, across random challenges, random memory contents and a single-byte tamper. They also check the exact number and first address of the reads, the total cycle figure for several iteration counts including zero, and that a job stays intact when start is pulsed during both the key schedule and the iteration phase.

// File: rtl/csum_pkg.sv
package csum_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCHED,
      ST_DROP,
      ST_FILL,
      ST_PREV,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } eng_state_e;

   typedef enum logic [1:0] {
      KS_IDLE,
      KS_MIX,
      KS_RUN
   } ks_phase_e;

   function automatic logic [7:0] rotl1(input logic [7:0] v);
      return {v[6:0], v[7]};
   endfunction

endpackage

// File: rtl/kstream_gen.sv
module kstream_gen
   import csum_pkg::*;
#(
   parameter int KEY_BYTES = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [KEY_BYTES*8-1:0] key,
   input  logic                   step,
   output logic                   ready,
   output logic [7:0]             ks_byte
);

   localparam int PERM_N = 256;
   localparam int KW     = $clog2(KEY_BYTES);

   if (KEY_BYTES < 2 || KEY_BYTES > PERM_N || (1 << KW) != KEY_BYTES) begin : g_bad_key
      $error("kstream_gen: KEY_BYTES must be a power of two in 2..256");
   end

   logic [7:0]             perm [PERM_N];
   logic [KEY_BYTES*8-1:0] key_q;
   logic [7:0]             key_arr [KEY_BYTES];
   logic [7:0]             pi, pj;
   ks_phase_e              phase;

   for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key_unpack
      assign key_arr[g] = key_q[8*g +: 8];
   end

   logic [7:0] ri, si, sj, jn, kb, tix;

   always_comb begin
      ri      = (phase == KS_RUN) ? pi + 8'd1 : pi;
      si      = perm[ri];
      kb      = (phase == KS_MIX) ? key_arr[pi[KW-1:0]] : 8'd0;
      jn      = pj + si + kb;
      sj      = perm[jn];
      tix     = si + sj;
      if (tix == ri)      ks_byte = sj;
      else if (tix == jn) ks_byte = si;
      else                ks_byte = perm[tix];
   end

   assign ready = (phase == KS_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= KS_IDLE;
         pi    <= '0;
         pj    <= '0;
         key_q <= '0;
         for (int k = 0; k < PERM_N; k++) perm[k] <= 8'(k);
      end else if (load) begin
         phase <= KS_MIX;
         pi    <= '0;
         pj    <= '0;
         key_q <= key;
         for (int k = 0; k < PERM_N; k++) perm[k] <= 8'(k);
      end else if (phase == KS_MIX || (phase == KS_RUN && step)) begin
         perm[ri] <= sj;
         perm[jn] <= si;
         if (phase == KS_MIX) begin
            if (pi == 8'hFF) begin
               phase <= KS_RUN;
               pi    <= '0;
               pj    <= '0;
            end else begin
               pi <= pi + 8'd1;
               pj <= jn;
            end
         end else begin
            pi <= ri;
            pj <= jn;
         end
      end
   end

   // R2
   step_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ready);

   // R2
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ready);

endmodule

// File: rtl/csum_lanes.sv
module csum_lanes #(
   parameter int LANES = 8,
   localparam int LW   = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LW-1:0]      widx,
   input  logic [7:0]         wdata,
   input  logic [LW-1:0]      ra_idx,
   output logic [7:0]         ra_data,
   input  logic [LW-1:0]      rb_idx,
   output logic [7:0]         rb_data,
   input  logic [LW-1:0]      rc_idx,
   output logic [7:0]         rc_data,
   output logic [LANES*8-1:0] flat
);

   logic [7:0] lane_q [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          lane_q[g] <= '0;
         else if (we && widx == LW'(g))       lane_q[g] <= wdata;
      end
      assign flat[8*g +: 8] = lane_q[g];
   end

   assign ra_data = lane_q[ra_idx];
   assign rb_data = lane_q[rb_idx];
   assign rc_data = lane_q[rc_idx];

endmodule

// File: rtl/cyc_meter.sv
module cyc_meter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   output logic [W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (run) count <= count + W'(1);
   end

endmodule

// File: rtl/trav_csum_engine.sv
module trav_csum_engine
   import csum_pkg::*;
#(
   parameter int KEY_BYTES = 16,
   parameter int LANES     = 8,
   parameter int ITER_W    = 24,
   parameter int CYC_W     = 32,
   parameter int MEM_LAT   = 1,
   parameter int DROP_N    = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [KEY_BYTES*8-1:0] seed,
   input  logic [ITER_W-1:0]      iters,
   output logic                   mem_rd,
   output logic [15:0]            mem_addr,
   input  logic [7:0]             mem_rdata,
   output logic [LANES*8-1:0]     csum,
   output logic                   done,
   output logic                   busy,
   output logic [CYC_W-1:0]       cycles
);

   localparam int LW   = $clog2(LANES);
   localparam int DW   = $clog2(DROP_N) + 1;
   localparam int LATW = $clog2(MEM_LAT + 2);

   if (LANES < 4 || (1 << LW) != LANES) begin : g_bad_lanes
      $error("trav_csum_engine: LANES must be a power of two >= 4");
   end
   if (DROP_N < 1) begin : g_bad_drop
      $error("trav_csum_engine: DROP_N must be at least 1");
   end
   if (MEM_LAT < 0) begin : g_bad_lat
      $error("trav_csum_engine: MEM_LAT must not be negative");
   end

   eng_state_e        st;
   logic [LW-1:0]     jidx, fill_q;
   logic [DW-1:0]     drop_q;
   logic [LATW-1:0]   lat_q;
   logic [ITER_W-1:0] iter_q, target_q;
   logic [7:0]        prev_q, cur_q;
   logic [15:0]       addr_q;
   logic              rd_q;

   logic              accept, ks_load, ks_step, ks_ready;
   logic [7:0]        ks_byte;
   logic              lat_hit;

   assign busy    = (st != ST_IDLE) && (st != ST_DONE);
   assign done    = (st == ST_DONE);
   assign accept  = start && !busy;
   assign ks_load = accept;
   assign ks_step = (st == ST_DROP) || (st == ST_FILL) ||
                    (st == ST_PREV) || (st == ST_ISSUE);
   assign lat_hit = (st == ST_WAIT) && (lat_q == LATW'(MEM_LAT));

   kstream_gen #(.KEY_BYTES(KEY_BYTES)) u_ks (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ks_load),
      .key     (seed),
      .step    (ks_step),
      .ready   (ks_ready),
      .ks_byte (ks_byte)
   );

   logic          ln_we;
   logic [LW-1:0] ln_widx;
   logic [7:0]    ln_wdata, c_cur, c_m1, c_m2, mixed;

   always_comb begin
      mixed    = rotl1(c_cur + ((mem_rdata ^ c_m2) + prev_q));
      ln_we    = (st == ST_FILL) || lat_hit;
      ln_widx  = (st == ST_FILL) ? fill_q : jidx;
      ln_wdata = (st == ST_FILL) ? ks_byte : mixed;
   end

   csum_lanes #(.LANES(LANES)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ln_we),
      .widx    (ln_widx),
      .wdata   (ln_wdata),
      .ra_idx  (jidx),
      .ra_data (c_cur),
      .rb_idx  (jidx - LW'(1)),
      .rb_data (c_m1),
      .rc_idx  (jidx - LW'(2)),
      .rc_data (c_m2),
      .flat    (csum)
   );

   cyc_meter #(.W(CYC_W)) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .run   (busy),
      .count (cycles)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         jidx     <= '0;
         fill_q   <= '0;
         drop_q   <= '0;
         lat_q    <= '0;
         iter_q   <= '0;
         target_q <= '0;
         prev_q   <= '0;
         cur_q    <= '0;
         addr_q   <= '0;
         rd_q     <= 1'b0;
      end else begin
         rd_q <= 1'b0;
         unique case (st)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  st       <= ST_SCHED;
                  target_q <= iters;
                  iter_q   <= '0;
                  jidx     <= '0;
               end
            end
            ST_SCHED: begin
               if (ks_ready) begin
                  st     <= ST_DROP;
                  drop_q <= '0;
               end
            end
            ST_DROP: begin
               drop_q <= drop_q + DW'(1);
               if (drop_q == DW'(DROP_N - 1)) begin
                  st     <= ST_FILL;
                  fill_q <= '0;
               end
            end
            ST_FILL: begin
               fill_q <= fill_q + LW'(1);
               if (fill_q == LW'(LANES - 1)) st <= ST_PREV;
            end
            ST_PREV: begin
               prev_q <= ks_byte;
               st     <= (target_q == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_ISSUE: begin
               cur_q  <= ks_byte;
               addr_q <= {ks_byte, c_m1};
               rd_q   <= 1'b1;
               lat_q  <= '0;
               st     <= ST_WAIT;
            end
            ST_WAIT: begin
               if (lat_hit) begin
                  prev_q <= cur_q;
                  jidx   <= jidx + LW'(1);
                  iter_q <= iter_q + ITER_W'(1);
                  st     <= (iter_q + ITER_W'(1) == target_q) ? ST_DONE : ST_ISSUE;
               end else begin
                  lat_q <= lat_q + LATW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd   = rd_q;
   assign mem_addr = addr_q;

   // R4
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> $stable(mem_addr));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(csum));

   // R9
   cyc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(cycles));

   // R9
   cyc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> cycles == $past(cycles) + CYC_W'(1));

   // R7
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> cycles != '0);

   // R10
   done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

endmodule

// File: tb/tb_trav_csum_engine.sv
`timescale 1ns/1ps
module tb_trav_csum_engine;

   localparam int TB_LAT = 1;
   localparam int BASE   = 256 + 1 + 256 + 8 + 1;
   localparam int PER_IT = TB_LAT + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] seed = '0;
   logic [23:0]  iters = '0;
   logic         mem_rd;
   logic [15:0]  mem_addr;
   logic [7:0]   mem_rdata;
   logic [63:0]  csum;
   logic         done, busy;
   logic [31:0]  cycles;

   always #4 clk = ~clk;

   trav_csum_engine #(.MEM_LAT(TB_LAT)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .iters(iters),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .csum(csum), .done(done), .busy(busy), .cycles(cycles)
   );

   int          n_chk = 0;
   int          n_err = 0;
   bit          finished = 0;
   logic [7:0]  salt = 8'h3C;
   bit          tamp_en = 0;
   logic [15:0] tamp_a = '0;

   function automatic logic [7:0] mem_fn(input logic [15:0] a);
      logic [7:0] v;
      v = (a[15:8] * 8'd29) ^ (a[7:0] * 8'd7) ^ salt ^ {a[3:0], a[15:12]};
      if (tamp_en && a == tamp_a) v = v ^ 8'h5A;
      return v;
   endfunction

   logic [7:0] pipe [TB_LAT];
   always @(posedge clk) begin
      if (mem_rd) pipe[0] <= mem_fn(mem_addr);
      for (int k = 1; k < TB_LAT; k++) pipe[k] <= pipe[k-1];
   end
   assign mem_rdata = pipe[TB_LAT-1];

   bit          clr_mon = 0;
   int          rd_count = 0;
   bit          got_first = 0;
   logic [15:0] first_addr = '0;
   always @(posedge clk) begin
      if (clr_mon) begin
         rd_count  <= 0;
         got_first <= 0;
      end else if (mem_rd) begin
         rd_count <= rd_count + 1;
         if (!got_first) begin
            got_first  <= 1;
            first_addr <= mem_addr;
         end
      end
   end

   logic [7:0] rs [256];
   logic [7:0] gi, gj;

   task prg_next(output logic [7:0] o);
      logic [7:0] t;
      gi = gi + 8'd1;
      gj = gj + rs[gi];
      t = rs[gi]; rs[gi] = rs[gj]; rs[gj] = t;
      o = rs[8'(rs[gi] + rs[gj])];
   endtask

   task ref_run(input logic [127:0] key, input int m,
                output logic [63:0] c_out, output logic [15:0] a0);
      logic [7:0] t, b, prev, k;
      logic [7:0] c [8];
      int jj;
      for (int n = 0; n < 256; n++) rs[n] = 8'(n);
      gj = 0;
      for (int n = 0; n < 256; n++) begin
         gj = gj + rs[n] + key[8*(n%16) +: 8];
         t = rs[n]; rs[n] = rs[gj]; rs[gj] = t;
      end
      gi = 0; gj = 0;
      for (int n = 0; n < 256; n++) prg_next(b);
      for (int n = 0; n < 8; n++) prg_next(c[n]);
      prg_next(prev);
      a0 = '0;
      jj = 0;
      for (int n = 0; n < m; n++) begin
         logic [15:0] a;
         prg_next(k);
         a = {k, c[(jj+7)%8]};
         if (n == 0) a0 = a;
         b = c[jj] + ((mem_fn(a) ^ c[(jj+6)%8]) + prev);
         c[jj] = {b[6:0], b[7]};
         prev = k;
         jj = (jj + 1) % 8;
      end
      for (int n = 0; n < 8; n++) c_out[8*n +: 8] = c[n];
   endtask

   task chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task finish_up();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   task launch(input logic [127:0] key, input int m);
      @(negedge clk);
      seed = key; iters = 24'(m); start = 1; clr_mon = 1;
      @(negedge clk);
      start = 0; clr_mon = 0;
   endtask

   task wait_done();
      int g;
      g = 0;
      while (!done && g < 20000) begin
         @(negedge clk);
         g++;
      end
      if (!done) begin
         chk(0, "watchdog", 64'(g), 64'd0);
         finish_up();
      end
   endtask

   task full_run(input logic [127:0] key, input int m, input string tag);
      logic [63:0] e; logic [15:0] a0;
      launch(key, m);
      wait_done();
      ref_run(key, m, e, a0);
      chk(csum == e, {tag, " R5 csum"}, csum, e);
      chk(rd_count == m, {tag, " R4 read count"}, 64'(rd_count), 64'(m));
      if (m > 0) chk(first_addr == a0, {tag, " R4 first addr"}, 64'(first_addr), 64'(a0));
      chk(cycles == 32'(BASE + m*PER_IT), {tag, " R6 R9 cycles"}, 64'(cycles), 64'(BASE + m*PER_IT));
   endtask

   initial begin
      #(200000 * 8);
      chk(0, "watchdog global", 64'd0, 64'd1);
      finish_up();
   end

   initial begin
      logic [63:0]  e, e0, snap;
      logic [15:0]  a0;
      logic [127:0] k;
      logic [31:0]  cy;
      void'($urandom(32'd2024));

      // R1 reset state
      #20;
      chk(done == 0 && busy == 0 && mem_rd == 0, "R1 flags", {61'd0, done, busy, mem_rd}, 64'd0);
      chk(cycles == 0 && csum == 0, "R1 values", csum | 64'(cycles), 64'd0);
      @(negedge clk); rst_n = 1;

      // R3 zero iterations: initial lanes only
      k = 128'h0f0e0d0c0b0a09080706050403020100;
      launch(k, 0);
      @(negedge clk); @(negedge clk);
      chk(busy == 1 && done == 0, "R10 busy mid-run", {62'd0, busy, done}, 64'd2);
      wait_done();
      ref_run(k, 0, e, a0);
      chk(csum == e, "R3 initial lanes", csum, e);
      chk(rd_count == 0, "R3 R4 no reads", 64'(rd_count), 64'd0);
      chk(cycles == BASE, "R9 base cycles", 64'(cycles), 64'(BASE));

      // R2 R5 directed keys and counts
      full_run('0, 1, "zero key m1");
      full_run({128{1'b1}}, 8, "ones key m8");
      full_run(128'h1, 20, "byte0 key m20");
      full_run({8'h01, 120'h0}, 20, "byte15 key m20");

      // R8 R9 done holds and meter freezes
      snap = csum; cy = cycles;
      repeat (20) @(negedge clk);
      chk(done == 1, "R8 done held", 64'(done), 64'd1);
      chk(csum == snap, "R8 csum stable", csum, snap);
      chk(cycles == cy, "R9 cycles frozen", 64'(cycles), 64'(cy));

      // R2 R4 R5 R6 random challenges and memory contents
      for (int r = 0; r < 8; r++) begin
         int m;
         k = {$urandom(), $urandom(), $urandom(), $urandom()};
         salt = 8'($urandom());
         m = 1 + ($urandom() % 300);
         full_run(k, m, "random");
      end

      // R5 single-byte tamper on a visited address changes the checksum
      k = 128'hdeadbeef_01234567_89abcdef_cafef00d;
      salt = 8'h77;
      ref_run(k, 600, e0, a0);
      tamp_en = 1; tamp_a = a0;
      full_run(k, 600, "tamper");
      chk(csum != e0, "R5 tamper detected", csum, e0);
      tamp_en = 0;

      // R7 start while busy ignored (during schedule and during iterations)
      k = 128'h55aa33cc_0f1e2d3c_4b5a6978_8796a5b4;
      launch(k, 50);
      repeat (100) @(negedge clk);
      seed = ~k; iters = 24'd3; start = 1;
      @(negedge clk); start = 0;
      repeat (500) @(negedge clk);
      seed = 128'h1; iters = 24'd2; start = 1;
      @(negedge clk); start = 0;
      wait_done();
      ref_run(k, 50, e, a0);
      chk(csum == e, "R7 result unchanged", csum, e);
      chk(cycles == 32'(BASE + 50*PER_IT), "R7 cycles unchanged", 64'(cycles), 64'(BASE + 50*PER_IT));
      chk(rd_count == 50, "R7 read count", 64'(rd_count), 64'd50);

      finish_up();
   end

endmodule